// File: doc/BRIEF.md
# Bit-Serial Processing Element Row

This block is a row of one-bit processing elements that work side by side on bit-slices. Each element owns one bit of three registers: a write-mask register M, an accumulator X and a response register Y. On every clock an operand vector `f_in` arrives from the permutation network. A 4-bit truth-table code selects one of the sixteen two-input Boolean functions. A mode code selects which of X and Y take the result, and whether the old Y gates the X update.

M is loaded from the same operand vector whenever `m_load` is high, in any mode. Its value drives the memory write mask. X, Y and M are all visible as full-width outputs, so a sequencer can route them back through the network. Multi-bit arithmetic across all elements at once is built from short sequences of these steps. For example, a four-step loop per bit position adds two fields and leaves the carry in Y.

Top module: `pe_row`

## Requirements
- R1: A synchronous `rst` high at a clock edge clears X, Y and M to all zeros, whatever the mode and `m_load` inputs are.
- R2: The function result for element i is `func[{r_i, f_i}]`: truth-table bit 2*r+f, where r is the register bit being updated. For example, 4'b1010 copies f, 4'b0110 is XOR and 4'b1000 is AND.
- R3: Mode 3'd1 updates only X with the function of (x_i, f_i). Y holds.
- R4: Mode 3'd2 updates only Y with the function of (y_i, f_i). X holds.
- R5: Mode 3'd3 updates X and Y in the same cycle, with the same function applied to (x_i, f_i) and (y_i, f_i).
- R6: Mode 3'd4 updates x_i only where y_i is 1 and holds x_i where y_i is 0. Y holds.
- R7: Mode 3'd5 updates Y in full and updates X only where the pre-update Y bit is 1.
- R8: Mode codes 3'd0, 3'd6 and 3'd7 change neither X nor Y.
- R9: When `m_load` is high, M takes `f_in` at the clock edge, in any mode. When `m_load` is low, M holds.
- R10: The add loop works across all elements. Per bit position it runs: mode 5 XOR with an a-slice, mode 5 XOR with a b-slice, the sum bit read from Y and then mode 4 XOR with f=Y, and mode 3 XOR with f=X. After the loop, every element holds its sum bits, its carry-out in Y, and a cleared X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 3 | Register update mode code |
| func | input | 4 | Truth table of the two-input function |
| m_load | input | 1 | Load M from the operand vector |
| f_in | input | N | Operand vector from the permutation network |
| x_out | output | N | X register contents |
| y_out | output | N | Y register contents |
| m_out | output | N | M register contents, the memory write mask |

## Verification
The bench builds the row with N=16 elements and the sum-of-products function variant. At that width, hand-derived 16-bit patterns can set up every combination of register bit, operand bit and Y mask in a single vector. A sweep of all sixteen truth-table codes covers the function selection in full. The add loop runs on 8-bit fields in every element, with random operands, and compares each element's sum and carry-out.

// File: rtl/pe_row_pkg.sv
package pe_row_pkg;
   localparam int FUNC_W = 4;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      PE_NOP   = 3'd0,
      PE_X     = 3'd1,
      PE_Y     = 3'd2,
      PE_XY    = 3'd3,
      PE_XM    = 3'd4,
      PE_XMY   = 3'd5
   } pe_mode_e;

   typedef struct packed {
      logic upd_x;
      logic upd_y;
      logic x_gated;
   } pe_ctrl_t;
endpackage

// File: rtl/pe_phi.sv
module pe_phi
   import pe_row_pkg::*;
#(
   parameter int N     = 256,
   parameter int STYLE = 0
) (
   input  logic [FUNC_W-1:0] func,
   input  logic [N-1:0]      r_in,
   input  logic [N-1:0]      f_in,
   output logic [N-1:0]      res
);
   generate
      if (STYLE == 0) begin : g_mux
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign res[i] = func[{r_in[i], f_in[i]}];
         end
      end else begin : g_sop
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign res[i] = (func[0] & ~r_in[i] & ~f_in[i])
                          | (func[1] & ~r_in[i] &  f_in[i])
                          | (func[2] &  r_in[i] & ~f_in[i])
                          | (func[3] &  r_in[i] &  f_in[i]);
         end
      end
   endgenerate
endmodule

// File: rtl/pe_mode_dec.sv
module pe_mode_dec
   import pe_row_pkg::*;
(
   input  logic [MODE_W-1:0] op_mode,
   output pe_ctrl_t          ctrl
);
   always_comb begin
      ctrl = '0;
      case (pe_mode_e'(op_mode))
         PE_X:    ctrl.upd_x = 1'b1;
         PE_Y:    ctrl.upd_y = 1'b1;
         PE_XY:   begin ctrl.upd_x = 1'b1; ctrl.upd_y = 1'b1; end
         PE_XM:   begin ctrl.upd_x = 1'b1; ctrl.x_gated = 1'b1; end
         PE_XMY:  begin ctrl.upd_x = 1'b1; ctrl.upd_y = 1'b1; ctrl.x_gated = 1'b1; end
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/pe_row.sv
module pe_row
   import pe_row_pkg::*;
#(
   parameter int N         = 256,
   parameter int PHI_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] op_mode,
   input  logic [FUNC_W-1:0] func,
   input  logic              m_load,
   input  logic [N-1:0]      f_in,
   output logic [N-1:0]      x_out,
   output logic [N-1:0]      y_out,
   output logic [N-1:0]      m_out
);
   generate
      if (N < 1) begin : g_bad_n
         $error("pe_row: N must be at least 1");
      end
      if (PHI_STYLE != 0 && PHI_STYLE != 1) begin : g_bad_style
         $error("pe_row: PHI_STYLE must be 0 or 1");
      end
   endgenerate

   logic [N-1:0] x_q, y_q, m_q;
   logic [N-1:0] phi_x, phi_y;
   logic [N-1:0] x_d, y_d;
   pe_ctrl_t     ctrl;

   pe_mode_dec u_dec (
      .op_mode (op_mode),
      .ctrl    (ctrl)
   );

   pe_phi #(.N(N), .STYLE(PHI_STYLE)) u_phi_x (
      .func  (func),
      .r_in  (x_q),
      .f_in  (f_in),
      .res   (phi_x)
   );

   pe_phi #(.N(N), .STYLE(PHI_STYLE)) u_phi_y (
      .func  (func),
      .r_in  (y_q),
      .f_in  (f_in),
      .res   (phi_y)
   );

   generate
      for (genvar i = 0; i < N; i++) begin : g_pe
         logic x_en;
         assign x_en   = ctrl.upd_x & (~ctrl.x_gated | y_q[i]);
         assign x_d[i] = x_en ? phi_x[i] : x_q[i];
         assign y_d[i] = ctrl.upd_y ? phi_y[i] : y_q[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
         y_q <= '0;
         m_q <= '0;
      end else begin
         x_q <= x_d;
         y_q <= y_d;
         if (m_load) m_q <= f_in;
      end
   end

   assign x_out = x_q;
   assign y_out = y_q;
   assign m_out = m_q;
endmodule

// File: rtl/pe_row_chk.sv
module pe_row_chk #(
   parameter int N = 256
) (
   input logic         clk,
   input logic         rst,
   input logic [2:0]   op_mode,
   input logic         m_load,
   input logic [N-1:0] f_in,
   input logic [N-1:0] x_out,
   input logic [N-1:0] y_out,
   input logic [N-1:0] m_out
);
   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (x_out == '0 && y_out == '0 && m_out == '0));

   a_r3_x_only_holds_y: assert property (@(posedge clk) disable iff (rst)
      (op_mode == 3'd1) |=> $stable(y_out));

   a_r4_y_only_holds_x: assert property (@(posedge clk) disable iff (rst)
      (op_mode == 3'd2) |=> $stable(x_out));

   a_r6_gated_x: assert property (@(posedge clk) disable iff (rst)
      (op_mode == 3'd4) |=>
         ($stable(y_out) && (((x_out ^ $past(x_out)) & ~$past(y_out)) == '0)));

   a_r7_old_y_mask: assert property (@(posedge clk) disable iff (rst)
      (op_mode == 3'd5) |=> (((x_out ^ $past(x_out)) & ~$past(y_out)) == '0));

   a_r8_nop_codes: assert property (@(posedge clk) disable iff (rst)
      (op_mode == 3'd0 || op_mode == 3'd6 || op_mode == 3'd7)
         |=> ($stable(x_out) && $stable(y_out)));

   a_r9_m_loads: assert property (@(posedge clk) disable iff (rst)
      m_load |=> (m_out == $past(f_in)));

   a_r9_m_holds: assert property (@(posedge clk) disable iff (rst)
      !m_load |=> $stable(m_out));
endmodule

bind pe_row pe_row_chk #(.N(N)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .op_mode (op_mode),
   .m_load  (m_load),
   .f_in    (f_in),
   .x_out   (x_out),
   .y_out   (y_out),
   .m_out   (m_out)
);

// File: tb/pe_row_tb.sv
module pe_row_tb;
   localparam int NB = 16;
   localparam int FW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic [2:0]    op_mode;
   logic [3:0]    func;
   logic          m_load;
   logic [NB-1:0] f_in;
   logic [NB-1:0] x_out, y_out, m_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pe_row #(.N(NB), .PHI_STYLE(1)) u_dut (
      .clk (clk), .rst (rst), .op_mode (op_mode), .func (func),
      .m_load (m_load), .f_in (f_in),
      .x_out (x_out), .y_out (y_out), .m_out (m_out)
   );

   typedef struct packed {
      logic [3:0]    req;
      logic [2:0]    mode;
      logic [3:0]    fn;
      logic [NB-1:0] f;
      logic [NB-1:0] ex;
      logic [NB-1:0] ey;
   } vec_t;

   // Applied in order from X=0, Y=0.
   localparam vec_t VECS [14] = '{
      '{4'd3,  3'd1, 4'hA, 16'hF0F0, 16'hF0F0, 16'h0000}, // R3 copy
      '{4'd4,  3'd2, 4'hA, 16'hFF00, 16'hF0F0, 16'hFF00}, // R4 copy
      '{4'd3,  3'd1, 4'h6, 16'h0FF0, 16'hFF00, 16'hFF00}, // R3 xor
      '{4'd5,  3'd3, 4'hE, 16'h000F, 16'hFF0F, 16'hFF0F}, // R5 or
      '{4'd2,  3'd1, 4'h8, 16'hF0FF, 16'hF00F, 16'hFF0F}, // R2 and
      '{4'd6,  3'd4, 4'h0, 16'h0000, 16'h0000, 16'hFF0F}, // R6 clear
      '{4'd6,  3'd4, 4'hF, 16'h1234, 16'hFF0F, 16'hFF0F}, // R6 set
      '{4'd4,  3'd2, 4'h3, 16'h0000, 16'hFF0F, 16'h00F0}, // R4 not
      '{4'd7,  3'd5, 4'h6, 16'hFFFF, 16'hFFFF, 16'hFF0F}, // R7 xor
      '{4'd8,  3'd0, 4'hF, 16'hAAAA, 16'hFFFF, 16'hFF0F}, // R8 code 0
      '{4'd8,  3'd7, 4'hF, 16'h1111, 16'hFFFF, 16'hFF0F}, // R8 code 7
      '{4'd5,  3'd3, 4'h3, 16'h0000, 16'h0000, 16'h00F0}, // R5 not
      '{4'd2,  3'd1, 4'h1, 16'h00FF, 16'hFF00, 16'h00F0}, // R2 nor
      '{4'd7,  3'd5, 4'hA, 16'h3C3C, 16'hFF30, 16'h3C3C}  // R7 copy
   };

   task automatic chk(input string req, input string what,
                      input logic [NB-1:0] got, input logic [NB-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   // Inputs are set just after a falling edge; results are read at the next one.
   task automatic cyc(input logic [2:0] md, input logic [3:0] fn,
                      input logic [NB-1:0] f, input logic ml);
      op_mode = md; func = fn; f_in = f; m_load = ml;
      @(negedge clk);
      op_mode = 3'd0; m_load = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [FW-1:0]   av [NB];
      logic [FW-1:0]   bv [NB];
      logic [FW:0]     sum [NB];
      logic [NB-1:0]   sl, exp_x;
      rst = 1'b1; op_mode = 3'd0; func = 4'h0; m_load = 1'b0; f_in = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk("R1", "x after reset", x_out, '0);
      chk("R1", "y after reset", y_out, '0);
      chk("R1", "m after reset", m_out, '0);

      foreach (VECS[k]) begin
         cyc(VECS[k].mode, VECS[k].fn, VECS[k].f, 1'b0);
         chk($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d x", k), x_out, VECS[k].ex);
         chk($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d y", k), y_out, VECS[k].ey);
      end

      // R8 code 6 leaves X and Y alone
      cyc(3'd6, 4'hF, 16'hFFFF, 1'b0);
      chk("R8", "code 6 x", x_out, 16'hFF30);
      chk("R8", "code 6 y", y_out, 16'h3C3C);

      // R2 sweep of all truth tables: x=3333, f=5555 covers every {r,f}
      do_reset();
      for (int fn = 0; fn < 16; fn++) begin
         cyc(3'd1, 4'hA, 16'h3333, 1'b0);
         cyc(3'd1, 4'(fn), 16'h5555, 1'b0);
         for (int i = 0; i < NB; i++) begin
            logic [3:0] t;
            t = 4'(fn);
            exp_x[i] = t[{1'b0, 16'h3333 >> i & 16'h1} * 2 + (16'h5555 >> i & 16'h1)];
         end
         chk("R2", $sformatf("func %0d", fn), x_out, exp_x);
      end
      chk("R3", "y held over sweep", y_out, '0);

      // R9 M load and hold
      cyc(3'd3, 4'hA, 16'hA5A5, 1'b1);
      chk("R9", "m loaded", m_out, 16'hA5A5);
      cyc(3'd1, 4'hF, 16'hFFFF, 1'b0);
      chk("R9", "m held", m_out, 16'hA5A5);
      cyc(3'd0, 4'h0, 16'h0F0F, 1'b1);
      chk("R9", "m loaded in nop", m_out, 16'h0F0F);
      chk("R9", "x unchanged by nop load", x_out, 16'hFFFF);

      // R1 reset wins over load and update
      rst = 1'b1; op_mode = 3'd3; func = 4'hF; m_load = 1'b1; f_in = '1;
      @(negedge clk);
      rst = 1'b0; op_mode = 3'd0; m_load = 1'b0;
      chk("R1", "x reset over mode", x_out, '0);
      chk("R1", "y reset over mode", y_out, '0);
      chk("R1", "m reset over load", m_out, '0);

      // R10 add loop, three rounds
      for (int rnd = 0; rnd < 3; rnd++) begin
         do_reset();
         for (int i = 0; i < NB; i++) begin
            av[i] = FW'($urandom);
            bv[i] = FW'($urandom);
            if (rnd == 0) begin av[i] = '1; bv[i] = FW'(i); end
            sum[i] = '0;
         end
         for (int k = 0; k < FW; k++) begin
            for (int i = 0; i < NB; i++) sl[i] = av[i][k];
            cyc(3'd5, 4'h6, sl, 1'b0);
            for (int i = 0; i < NB; i++) sl[i] = bv[i][k];
            cyc(3'd5, 4'h6, sl, 1'b0);
            for (int i = 0; i < NB; i++) sum[i][k] = y_out[i];
            cyc(3'd4, 4'h6, y_out, 1'b0);
            cyc(3'd3, 4'h6, x_out, 1'b0);
         end
         for (int i = 0; i < NB; i++) begin
            sum[i][FW] = y_out[i];
            total++;
            if (sum[i] !== ({1'b0, av[i]} + {1'b0, bv[i]})) begin
               bad++;
               $display("FAIL R10 round %0d pe %0d: actual=%h expected=%h",
                        rnd, i, sum[i], {1'b0, av[i]} + {1'b0, bv[i]});
            end
         end
         chk("R10", "x cleared after add", x_out, '0);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule